// File: doc/BRIEF.md
# Multi-Version Speculative Store Buffer

This block holds the stores of up to four speculative threads that run successive iterations of one loop inside a core. Every thread owns a private slice of entries, and each entry is one 4-byte granule with an address, data and a byte mask. Buffered data stays out of the cache until the owning thread becomes the oldest and is committed. A thread's age is its distance from the oldest thread, counted modulo the thread count. After a commit the retired identifier becomes the youngest.

A load gives a thread identifier and a granule address. The block compares the address against every slice in parallel and merges the result with the word the backing cache returns for that address. Each byte takes the newest matching store from the reading thread or from any older thread. Bytes that no such store writes come from the cache. Stores made by younger threads do not affect the result. A commit drains the oldest slice into the cache through a valid/ready write port, one entry per accepted beat, in store order. A squash clears the named thread and every younger thread. A coherence request from another core that names a line held by a speculative slice squashes the oldest thread that holds the line, together with every younger thread.

Top module: `spec_store_buf`

## Requirements
- R1: After reset no stall is raised, no write is offered to the cache, no thread is killed, commit_done is low, oldest_tid is 0, and a load returns the cache word unchanged.
- R2: A load by thread T returns, for each byte, the newest store to that granule by T or by a thread older than T. Stores by threads younger than T are ignored, and bytes that no such store writes come from cache_rd_data.
- R3: Stores carry a 4-bit byte mask in which bit b enables data bits [8b+7:8b]. Within and across threads, a newer store replaces only the bytes it enables.
- R4: A slice that holds DEPTH entries raises its bit of st_stall. A store offered to a stalled thread is dropped and leaves every later load unchanged.
- R5: During a commit, the oldest slice's entries are presented on the cache write port in store order, one per cycle in which cache_wr_valid and cache_wr_ready are both high. While ready is low, valid, address and data hold steady.
- R6: Buffered stores reach the cache only through a commit. commit_done is high in the cycle of the last accepted write, or in the cycle after commit when the slice is empty. The slice is then emptied and oldest_tid advances by one, wrapping.
- R7: sq_valid with sq_tid clears that thread and every younger thread at the next clock edge. kill_mask shows those threads in the same cycle.
- R8: While a commit drains, a squash that names the oldest thread spares it and clears only the younger threads.
- R9: snp_valid with a line address (granule address shifted right by LINE_SHIFT=2) that matches an entry of a speculative slice kills the oldest matching thread and every younger thread. A line that no speculative slice holds kills nothing.
- R10: Thread age is (tid - oldest_tid) mod NTHR. After commits wrap the identifiers, a thread with a lower number can be younger than one with a higher number.
- R11: While its slice drains, the oldest thread's st_stall bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Store request |
| st_tid | input | 2 | Storing thread |
| st_addr | input | 16 | Store granule address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte mask |
| st_stall | output | 4 | Per-thread stall (slice full or draining) |
| ld_tid | input | 2 | Loading thread |
| ld_addr | input | 16 | Load granule address |
| ld_data | output | 32 | Merged load result |
| cache_rd_addr | output | 16 | Address sent to the cache read port |
| cache_rd_data | input | 32 | Cache word for cache_rd_addr |
| commit | input | 1 | Start draining the oldest slice |
| commit_done | output | 1 | Drain finishes this cycle |
| cache_wr_valid | output | 1 | Drain write offered |
| cache_wr_ready | input | 1 | Cache accepts the write |
| cache_wr_addr | output | 16 | Drain write address |
| cache_wr_data | output | 32 | Drain write data |
| cache_wr_be | output | 4 | Drain write byte mask |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | 2 | First thread to squash |
| snp_valid | input | 1 | External coherence request |
| snp_line | input | 14 | Requested line address |
| kill_mask | output | 4 | Threads cleared at the next edge |
| oldest_tid | output | 2 | Current oldest (committable) thread |

## Verification
Several checks run on every clock. The write port must hold while it is stalled by ready. The oldest pointer may move only on commit_done, and then by exactly one. Every killed slice must be empty one cycle later, and kill_mask must always be a contiguous run that extends to the youngest thread. The draining thread must never appear in kill_mask, and a stalled slice that is neither killed nor committed must not grow. Only the bench's scenarios can show the per-byte merge order across slices, that younger stores are ignored, the exact drain order, the cache contents after a commit, and the effect of a snoop on matching and non-matching lines.

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int NTHR       = 4,
  parameter int DEPTH      = 4,
  parameter int AW         = 16,
  parameter int GB         = 4,
  parameter int LINE_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [$clog2(NTHR)-1:0]  st_tid,
  input  logic [AW-1:0]            st_addr,
  input  logic [8*GB-1:0]          st_data,
  input  logic [GB-1:0]            st_be,
  output logic [NTHR-1:0]          st_stall,
  input  logic [$clog2(NTHR)-1:0]  ld_tid,
  input  logic [AW-1:0]            ld_addr,
  output logic [8*GB-1:0]          ld_data,
  output logic [AW-1:0]            cache_rd_addr,
  input  logic [8*GB-1:0]          cache_rd_data,
  input  logic                     commit,
  output logic                     commit_done,
  output logic                     cache_wr_valid,
  input  logic                     cache_wr_ready,
  output logic [AW-1:0]            cache_wr_addr,
  output logic [8*GB-1:0]          cache_wr_data,
  output logic [GB-1:0]            cache_wr_be,
  input  logic                     sq_valid,
  input  logic [$clog2(NTHR)-1:0]  sq_tid,
  input  logic                     snp_valid,
  input  logic [AW-LINE_SHIFT-1:0] snp_line,
  output logic [NTHR-1:0]          kill_mask,
  output logic [$clog2(NTHR)-1:0]  oldest_tid
);
  localparam int TW = $clog2(NTHR);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int DW = 8 * GB;

  logic [AW-1:0] e_addr [NTHR][DEPTH];
  logic [DW-1:0] e_data [NTHR][DEPTH];
  logic [GB-1:0] e_be   [NTHR][DEPTH];
  logic [CW-1:0] cnt    [NTHR];
  logic [TW-1:0] oldest;
  logic          draining;
  logic [CW-1:0] dptr;

  logic          st_fire, wr_fire;
  logic [TW:0]   sq_age, snp_age, kill_from;
  logic [TW-1:0] ld_age;

  assign oldest_tid    = oldest;
  assign cache_rd_addr = ld_addr;

  always_comb begin
    for (int t = 0; t < NTHR; t++)
      st_stall[t] = (cnt[t] == CW'(DEPTH)) || (draining && TW'(t) == oldest);
  end

  assign st_fire = st_valid && !st_stall[st_tid] && !kill_mask[st_tid];

  always_comb begin
    logic [TW-1:0] tt;
    ld_age  = ld_tid - oldest;
    ld_data = cache_rd_data;
    for (int a = 0; a < NTHR; a++) begin
      tt = oldest + TW'(a);
      if (TW'(a) <= ld_age) begin
        for (int e = 0; e < DEPTH; e++) begin
          if (CW'(e) < cnt[tt] && e_addr[tt][e] == ld_addr) begin
            for (int b = 0; b < GB; b++)
              if (e_be[tt][e][b]) ld_data[8*b +: 8] = e_data[tt][e][8*b +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    logic [TW-1:0] tt;
    snp_age = (TW+1)'(NTHR);
    for (int a = NTHR - 1; a >= 0; a--) begin
      tt = oldest + TW'(a);
      if (snp_valid && !(draining && a == 0)) begin
        for (int e = 0; e < DEPTH; e++)
          if (CW'(e) < cnt[tt] && e_addr[tt][e][AW-1:LINE_SHIFT] == snp_line)
            snp_age = (TW+1)'(a);
      end
    end
  end

  always_comb begin
    sq_age = (TW+1)'(NTHR);
    if (sq_valid) begin
      sq_age = {1'b0, sq_tid - oldest};
      if (draining && sq_age == '0) sq_age = (TW+1)'(1);
    end
    kill_from = (sq_age < snp_age) ? sq_age : snp_age;
    for (int t = 0; t < NTHR; t++)
      kill_mask[t] = {1'b0, TW'(t) - oldest} >= kill_from;
  end

  assign cache_wr_valid = draining && (dptr < cnt[oldest]);
  assign cache_wr_addr  = e_addr[oldest][dptr[PW-1:0]];
  assign cache_wr_data  = e_data[oldest][dptr[PW-1:0]];
  assign cache_wr_be    = e_be[oldest][dptr[PW-1:0]];
  assign wr_fire        = cache_wr_valid && cache_wr_ready;
  assign commit_done    = draining && (wr_fire ? (dptr + CW'(1) == cnt[oldest])
                                               : (dptr == cnt[oldest]));

  always_ff @(posedge clk) begin
    if (st_fire) begin
      e_addr[st_tid][cnt[st_tid][PW-1:0]] <= st_addr;
      e_data[st_tid][cnt[st_tid][PW-1:0]] <= st_data;
      e_be[st_tid][cnt[st_tid][PW-1:0]]   <= st_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) cnt[t] <= '0;
      oldest   <= '0;
      draining <= 1'b0;
      dptr     <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (kill_mask[t]) cnt[t] <= '0;
        else if (st_fire && st_tid == TW'(t)) cnt[t] <= cnt[t] + CW'(1);
      end
      if (wr_fire) dptr <= dptr + CW'(1);
      if (commit_done) begin
        draining    <= 1'b0;
        cnt[oldest] <= '0;
        oldest      <= oldest + TW'(1);
      end else if (commit && !draining) begin
        draining <= 1'b1;
        dptr     <= '0;
      end
    end
  end
endmodule

module spec_store_buf_chk #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cache_wr_valid,
  input logic                    cache_wr_ready,
  input logic [AW-1:0]           cache_wr_addr,
  input logic [DW-1:0]           cache_wr_data,
  input logic                    commit_done,
  input logic [$clog2(NTHR)-1:0] oldest_tid,
  input logic [NTHR-1:0]         kill_mask,
  input logic [NTHR-1:0]         st_stall,
  input logic                    draining,
  input logic [$clog2(DEPTH+1)-1:0] cnt [NTHR]
);
  localparam int TW = $clog2(NTHR);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_valid && !cache_wr_ready |=>
      cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data));

  // R6
  oldest_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_done |=> $stable(oldest_tid));

  // R6
  oldest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> oldest_tid == $past(oldest_tid) + TW'(1));

  // R8
  drain_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !kill_mask[oldest_tid]);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    // R7
    kill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_mask[t] |=> cnt[t] == '0);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall[t] && !kill_mask[t] && !commit_done |=> cnt[t] == $past(cnt[t]));
  end

  for (genvar a = 0; a < NTHR - 1; a++) begin : g_age
    // R7
    kill_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_mask[oldest_tid + TW'(a)] |-> kill_mask[oldest_tid + TW'(a + 1)]);
  end
endmodule

bind spec_store_buf spec_store_buf_chk #(.NTHR(NTHR), .DEPTH(DEPTH), .AW(AW), .DW(8*GB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
  .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data), .commit_done(commit_done),
  .oldest_tid(oldest_tid), .kill_mask(kill_mask), .st_stall(st_stall), .draining(draining),
  .cnt(cnt)
);

// File: tb/tb_spec_store_buf.sv
module tb_spec_store_buf;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        st_valid = 0;
  logic [1:0]  st_tid = 0;
  logic [15:0] st_addr = 0;
  logic [31:0] st_data = 0;
  logic [3:0]  st_be = 0;
  logic [3:0]  st_stall;
  logic [1:0]  ld_tid = 0;
  logic [15:0] ld_addr = 0;
  logic [31:0] ld_data;
  logic [15:0] cache_rd_addr;
  logic [31:0] cache_rd_data;
  logic        commit = 0;
  logic        commit_done;
  logic        cache_wr_valid;
  logic        cache_wr_ready = 0;
  logic [15:0] cache_wr_addr;
  logic [31:0] cache_wr_data;
  logic [3:0]  cache_wr_be;
  logic        sq_valid = 0;
  logic [1:0]  sq_tid = 0;
  logic        snp_valid = 0;
  logic [13:0] snp_line = 0;
  logic [3:0]  kill_mask;
  logic [1:0]  oldest_tid;

  int n_chk = 0, n_fail = 0, nw = 0;
  logic [31:0] mem [16];
  logic [15:0] wlog [8];

  always #4 clk = ~clk;

  spec_store_buf dut (.*);

  assign cache_rd_data = mem[cache_rd_addr[3:0]];

  always @(posedge clk) begin
    if (cache_wr_valid && cache_wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (cache_wr_be[b]) mem[cache_wr_addr[3:0]][8*b +: 8] <= cache_wr_data[8*b +: 8];
      if (nw < 8) wlog[nw] <= cache_wr_addr;
      nw <= nw + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input logic [1:0] t, input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    st_valid = 1; st_tid = t; st_addr = a; st_data = d; st_be = be;
    @(posedge clk); #1 st_valid = 0;
  endtask

  task automatic load(input logic [1:0] t, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    ld_tid = t; ld_addr = a;
    #1 d = ld_data;
  endtask

  task automatic start_commit();
    @(negedge clk); commit = 1;
    @(posedge clk); #1 commit = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (commit_done) begin
        @(posedge clk); #1;
        break;
      end
    end
  endtask

  // {tid, addr, expected}
  localparam logic [37:0] VEC [8] = '{
    {2'd0, 4'd2, 32'h11111111},
    {2'd1, 4'd2, 32'h11112255},
    {2'd2, 4'd2, 32'h11112255},
    {2'd3, 4'd2, 32'h44112255},
    {2'd0, 4'd5, 32'hC0DE0005},
    {2'd2, 4'd5, 32'h33333333},
    {2'd3, 4'd5, 32'h33333333},
    {2'd1, 4'd7, 32'hC0DE0007}
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE0000 | i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    load(0, 3, d);
    check("R1 stall", {28'd0, st_stall}, 0);
    check("R1 wr_valid", {31'd0, cache_wr_valid}, 0);
    check("R1 kill", {28'd0, kill_mask}, 0);
    check("R1 oldest", {30'd0, oldest_tid}, 0);
    check("R1 done", {31'd0, commit_done}, 0);
    check("R1 load", d, 32'hC0DE0003);

    store(0, 2, 32'h11111111, 4'hF);
    store(1, 2, 32'h22222222, 4'h3);
    store(2, 5, 32'h33333333, 4'hF);
    store(3, 2, 32'h44444444, 4'h8);
    store(1, 2, 32'h55555555, 4'h1);
    check("R6 no early write", {31'd0, cache_wr_valid}, 0);
    check("R6 cache untouched", mem[2], 32'hC0DE0002);

    // R2 R3 vector walk
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][37:36], {12'd0, VEC[i][35:32]}, d);
      check($sformatf("R2/R3 vec%0d", i), d, VEC[i][31:0]);
    end

    // R4 fill thread 2, then a dropped store
    store(2, 9, 32'hAAAA0009, 4'hF);
    store(2, 10, 32'hAAAA000A, 4'hF);
    store(2, 11, 32'hAAAA000B, 4'hF);
    @(negedge clk);
    check("R4 stall full", {28'd0, st_stall}, 32'h4);
    store(2, 5, 32'h99999999, 4'hF);
    load(2, 5, d);
    check("R4 dropped store", d, 32'h33333333);

    // R5 commit thread 0 with ready held low
    cache_wr_ready = 0;
    start_commit();
    check("R5 valid", {31'd0, cache_wr_valid}, 1);
    check("R5 addr", {16'd0, cache_wr_addr}, 2);
    check("R11 drain stall", {31'd0, st_stall[0]}, 1);
    @(posedge clk); #1;
    check("R5 hold valid", {31'd0, cache_wr_valid}, 1);
    check("R5 hold data", cache_wr_data, 32'h11111111);
    cache_wr_ready = 1;
    wait_done();
    check("R6 oldest after", {30'd0, oldest_tid}, 1);
    check("R6 cache written", mem[2], 32'h11111111);
    check("R5 one write", nw, 1);

    // R10 wrap: thread 0 is now youngest
    load(0, 2, d);
    check("R10 youngest sees all", d, 32'h44112255);
    load(1, 2, d);
    check("R10 oldest own", d, 32'h11112255);

    // commit thread 1 (two entries, in order)
    start_commit();
    wait_done();
    check("R5 order count", nw, 3);
    check("R5 order first", {16'd0, wlog[1]}, 2);
    check("R6 merged cache", mem[2], 32'h11112255);
    check("R6 oldest wrap step", {30'd0, oldest_tid}, 2);

    // R7 squash thread 3 (age 1)
    @(negedge clk);
    sq_valid = 1; sq_tid = 3;
    #1 check("R7 kill mask", {28'd0, kill_mask}, 32'hB);
    @(posedge clk); #1 sq_valid = 0;
    load(3, 2, d);
    check("R7 cleared", d, 32'h11112255);
    load(2, 5, d);
    check("R7 older kept", d, 32'h33333333);

    // R9 snoops
    store(3, 13, 32'h77777777, 4'hF);
    store(0, 14, 32'h88888888, 4'hF);
    @(negedge clk);
    snp_valid = 1; snp_line = 0;
    #1 check("R9 miss", {28'd0, kill_mask}, 0);
    snp_line = 3;
    #1 check("R9 hit mask", {28'd0, kill_mask}, 32'hB);
    @(posedge clk); #1 snp_valid = 0;
    load(0, 14, d);
    check("R9 squashed data", d, 32'hC0DE000E);
    check("R9 older slice kept", {31'd0, st_stall[2]}, 1);

    // R8 squash of draining thread 2
    cache_wr_ready = 0;
    start_commit();
    @(negedge clk);
    sq_valid = 1; sq_tid = 2;
    #1 check("R8 spare drain", {28'd0, kill_mask}, 32'hB);
    @(posedge clk); #1 sq_valid = 0;
    cache_wr_ready = 1;
    wait_done();
    check("R8 drain completed", nw, 7);
    check("R5 last addr", {16'd0, wlog[6]}, 11);
    check("R8 cache data", mem[5], 32'h33333333);
    check("R6 oldest 3", {30'd0, oldest_tid}, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule